// File: doc/BRIEF.md
# Trail Trace Identifier Insertion Buffer

This block stores a 64-byte trail trace identifier for insertion into an outgoing overhead field. The storage is 32 words of 16 bits, each word carrying two identifier bytes. A host port reaches the storage through one access register. The host can read it, write it, or both in the same cycle, and every access moves a single shared word pointer forward by one. A separate pointer-load strobe places that pointer at any word.

The framing side presents an 8-bit multiframe alignment count together with a frame strobe. The block returns, in a register, the identifier byte that belongs to that frame. The low six bits of the count index the 64 bytes, so the sequence restarts at byte 0 every 64 frames. Byte 0 goes out on counts 0x00, 0x40, 0x80 and 0xC0. Host activity never stalls the frame-side output.

Top module: `tti_insert_buf`

## Requirements
- R1: After reset, the pointer, the host read data, the frame-side byte and every stored byte are 0x00.
- R2: Identifier byte 2k is held in bits 7:0 of word k, and byte 2k+1 is held in bits 15:8 of word k, for k = 0 to 31.
- R3: Each host access cycle moves the pointer forward by exactly one word. A host access cycle is one with a read strobe, a write strobe, or both. A host write stores `host_wdata_i` at the word the pointer held before the access.
- R4: A pointer-load strobe sets the pointer to `ptr_val_i` in the next cycle. Any read or write strobe in that same cycle is ignored: no memory change, no read data change, no extra increment.
- R5: The pointer is 5 bits wide and wraps from word 31 to word 0 on the next access.
- R6: A host read places the word at the current pointer on `host_rdata_o` one cycle after the strobe. The value holds until the next host read.
- R7: When read and write strobes coincide, the read returns the word's contents from before the write, and the new data is stored.
- R8: On a frame strobe, the selected byte index is `mfas_i[5:0]`. Bits 5:1 choose the word and bit 0 chooses the byte lane, so counts 0x00, 0x40, 0x80 and 0xC0 all yield byte 0.
- R9: `tti_byte_o` updates one cycle after a frame strobe and holds its value while no strobe is present, whatever `mfas_i` does.
- R10: A host write is visible to a frame strobe issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe on the access register |
| host_rd_i | input | 1 | Host read strobe on the access register |
| host_wdata_i | input | 16 | Host write word |
| host_rdata_o | output | 16 | Host read word, registered |
| ptr_load_i | input | 1 | Pointer-load strobe |
| ptr_val_i | input | 5 | Pointer value to load |
| ptr_o | output | 5 | Current host word pointer |
| mfas_i | input | 8 | Multiframe alignment count |
| frame_stb_i | input | 1 | Frame strobe |
| tti_byte_o | output | 8 | Identifier byte for the current frame, registered |

## Verification
On every cycle, the assertions check the pointer: a single increment per access cycle, a priority load, and no movement when idle. They also check that read data holds without a read strobe and that the frame byte holds without a frame strobe. Byte packing and the index taken from the alignment count can only be shown by the bench scenarios, as can the read-before-write result of a combined access. The same goes for write-to-frame visibility in the next cycle and wrap-around after 32 accesses. The bench shows these by filling the buffer with distinct patterns and comparing against its own model.

// File: rtl/tti_pkg.sv
package tti_pkg;
  localparam int unsigned TTI_BYTES = 64;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned LANES     = 2;
  localparam int unsigned MF_W      = 8;
endpackage

// File: rtl/tti_ptr.sv
module tti_ptr #(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (step_i) ptr_o <= ptr_o + AW'(1);  // natural wrap
  end
endmodule

// File: rtl/tti_store.sv
module tti_store #(
  parameter int unsigned WORDS  = 32,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned AW     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic [AW-1:0]     frm_addr_i,
  output logic [WORD_W-1:0] frm_word_o
);
  logic [WORD_W-1:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[g] <= '0;
      else if (wr_en_i && addr_i == AW'(g))     mem_q[g] <= wdata_i;
    end
  end

  // read samples pre-write contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mem_q[addr_i];
  end

  assign frm_word_o = mem_q[frm_addr_i];
endmodule

// File: rtl/tti_byte_sel.sv
module tti_byte_sel #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned LB     = $clog2(LANES),
  localparam int unsigned WORD_W = BYTE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [LB-1:0]     lane_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] lane_w [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_w[g] = word_i[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    byte_o <= '0;
    else if (stb_i) byte_o <= lane_w[lane_i];
  end
endmodule

// File: rtl/tti_insert_buf.sv
module tti_insert_buf
  import tti_pkg::*;
#(
  parameter int unsigned NBYTES = TTI_BYTES,
  parameter int unsigned BW     = BYTE_W,
  parameter int unsigned NLANE  = LANES,
  parameter int unsigned MFW    = MF_W,
  localparam int unsigned LB     = $clog2(NLANE),
  localparam int unsigned IDX_W  = $clog2(NBYTES),
  localparam int unsigned AW     = IDX_W - LB,
  localparam int unsigned WORDS  = NBYTES / NLANE,
  localparam int unsigned WORD_W = BW * NLANE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  input  logic              ptr_load_i,
  input  logic [AW-1:0]     ptr_val_i,
  output logic [AW-1:0]     ptr_o,
  input  logic [MFW-1:0]    mfas_i,
  input  logic              frame_stb_i,
  output logic [BW-1:0]     tti_byte_o
);
  logic          wr_en, rd_en, step;
  logic [IDX_W-1:0] idx;
  logic [WORD_W-1:0] frm_word;

  // load takes priority, access in that cycle is dropped
  assign wr_en = host_wr_i & ~ptr_load_i;
  assign rd_en = host_rd_i & ~ptr_load_i;
  assign step  = wr_en | rd_en;
  assign idx   = mfas_i[IDX_W-1:0];

  if (MFW > IDX_W) begin : g_mf_hi
    logic unused_mf_hi;
    assign unused_mf_hi = ^mfas_i[MFW-1:IDX_W];
  end

  tti_ptr #(.AW(AW)) u_ptr (
    .clk_i, .rst_ni,
    .load_i    (ptr_load_i),
    .load_val_i(ptr_val_i),
    .step_i    (step),
    .ptr_o     (ptr_o)
  );

  tti_store #(.WORDS(WORDS), .WORD_W(WORD_W), .AW(AW)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .addr_i    (ptr_o),
    .wdata_i   (host_wdata_i),
    .rdata_o   (host_rdata_o),
    .frm_addr_i(idx[IDX_W-1:LB]),
    .frm_word_o(frm_word)
  );

  tti_byte_sel #(.BYTE_W(BW), .LANES(NLANE)) u_sel (
    .clk_i, .rst_ni,
    .stb_i (frame_stb_i),
    .lane_i(idx[LB-1:0]),
    .word_i(frm_word),
    .byte_o(tti_byte_o)
  );
endmodule

// File: rtl/tti_insert_buf_chk.sv
module tti_insert_buf_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BW = 8,
  parameter int unsigned MFW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic [WORD_W-1:0] host_wdata_i,
  input logic [WORD_W-1:0] host_rdata_o,
  input logic              ptr_load_i,
  input logic [AW-1:0]     ptr_val_i,
  input logic [AW-1:0]     ptr_o,
  input logic [MFW-1:0]    mfas_i,
  input logic              frame_stb_i,
  input logic [BW-1:0]     tti_byte_o
);
  p_ptr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_load_i && (host_rd_i || host_wr_i)) |=> ptr_o == AW'($past(ptr_o) + AW'(1)));

  p_ptr_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_load_i && !host_rd_i && !host_wr_i) |=> $stable(ptr_o));

  p_ptr_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load_i |=> ptr_o == $past(ptr_val_i));

  p_load_no_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load_i |=> $stable(host_rdata_o));

  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_i |=> $stable(host_rdata_o));

  p_byte_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_stb_i |=> $stable(tti_byte_o));

  logic unused_chk;
  assign unused_chk = ^{host_wdata_i, mfas_i};
endmodule

bind tti_insert_buf tti_insert_buf_chk #(.AW(AW), .WORD_W(WORD_W), .BW(BW), .MFW(MFW)) u_chk (.*);

// File: tb/tti_insert_buf_test.sv
module tti_insert_buf_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_wr_i = 1'b0, host_rd_i = 1'b0, ptr_load_i = 1'b0, frame_stb_i = 1'b0;
  logic [15:0] host_wdata_i = '0;
  logic [15:0] host_rdata_o;
  logic [4:0]  ptr_val_i = '0;
  logic [4:0]  ptr_o;
  logic [7:0]  mfas_i = '0;
  logic [7:0]  tti_byte_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] mdl [32];
  logic [4:0]  mptr = '0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  tti_insert_buf uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(int n);
    return mdl[n >> 1][(n & 1) * 8 +: 8];
  endfunction

  task automatic hwr(logic [15:0] d);
    host_wr_i = 1; host_wdata_i = d;
    @(negedge clk_i); host_wr_i = 0;
    mdl[mptr] = d; mptr = mptr + 5'd1;
  endtask

  task automatic hrd(output logic [15:0] d);
    host_rd_i = 1;
    @(negedge clk_i); host_rd_i = 0;
    d = host_rdata_o; mptr = mptr + 5'd1;
  endtask

  task automatic frm(logic [7:0] m);
    frame_stb_i = 1; mfas_i = m;
    @(negedge clk_i); frame_stb_i = 0;
  endtask

  task automatic t_reset;
    chk("R1 ptr", 32'(ptr_o), 0);
    chk("R1 rdata", 32'(host_rdata_o), 0);
    chk("R1 byte", 32'(tti_byte_o), 0);
    frm(8'h3F);
    chk("R1 stored byte 63", 32'(tti_byte_o), 0);
  endtask

  task automatic t_fill;
    for (int k = 0; k < 32; k++)
      hwr({8'(2*k+1) ^ 8'hA5, 8'(2*k) ^ 8'h5A});
    chk("R5 wrap after 32 writes", 32'(ptr_o), 0);
  endtask

  task automatic t_read_all;
    logic [15:0] d;
    for (int k = 0; k < 32; k++) begin
      hrd(d);
      chk("R3/R6 read word", 32'(d), 32'(mdl[k]));
    end
    chk("R5 wrap after 32 reads", 32'(ptr_o), 0);
    repeat (3) @(negedge clk_i);
    chk("R6 rdata hold", 32'(host_rdata_o), 32'(mdl[31]));
  endtask

  task automatic t_frame;
    logic [7:0] ms [8] = '{8'h00, 8'h40, 8'h80, 8'hC0, 8'h01, 8'h3F, 8'h7E, 8'hA3};
    for (int i = 0; i < 8; i++) begin
      frm(ms[i]);
      chk("R8/R2 frame byte", 32'(tti_byte_o), 32'(mbyte(int'(ms[i][5:0]))));
    end
    mfas_i = 8'h05;
    repeat (3) @(negedge clk_i);
    chk("R9 hold without strobe", 32'(tti_byte_o), 32'(mbyte(6'h23)));
  endtask

  task automatic t_load;
    logic [15:0] d, keep;
    ptr_load_i = 1; ptr_val_i = 5'd17;
    @(negedge clk_i); ptr_load_i = 0; mptr = 5'd17;
    chk("R4 load", 32'(ptr_o), 17);
    hrd(d);
    chk("R4 read after load", 32'(d), 32'(mdl[17]));
    keep = host_rdata_o;
    ptr_load_i = 1; ptr_val_i = 5'd3; host_rd_i = 1; host_wr_i = 1; host_wdata_i = 16'hDEAD;
    @(negedge clk_i); ptr_load_i = 0; host_rd_i = 0; host_wr_i = 0; mptr = 5'd3;
    chk("R4 load beats access ptr", 32'(ptr_o), 3);
    chk("R4 rdata untouched", 32'(host_rdata_o), 32'(keep));
    frm(8'h24);  // byte 36 = word 18 low
    chk("R4 no write on load", 32'(tti_byte_o), 32'(mbyte(36)));
  endtask

  task automatic t_rw_both;
    logic [15:0] d;
    host_rd_i = 1; host_wr_i = 1; host_wdata_i = 16'hBEEF;
    @(negedge clk_i); host_rd_i = 0; host_wr_i = 0;
    chk("R7 read old", 32'(host_rdata_o), 32'(mdl[3]));
    chk("R3 single step", 32'(ptr_o), 4);
    mdl[3] = 16'hBEEF;
    ptr_load_i = 1; ptr_val_i = 5'd3;
    @(negedge clk_i); ptr_load_i = 0; mptr = 5'd3;
    hrd(d);
    chk("R7 new stored", 32'(d), 32'hBEEF);
  endtask

  task automatic t_write_frame;
    ptr_load_i = 1; ptr_val_i = 5'd0;
    @(negedge clk_i); ptr_load_i = 0; mptr = 5'd0;
    hwr(16'h1234);
    frm(8'h80);
    chk("R10 new low byte", 32'(tti_byte_o), 32'h34);
    frm(8'hC1);
    chk("R10/R2 new high byte", 32'(tti_byte_o), 32'h12);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) mdl[k] = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_fill();
    t_read_all();
    t_frame();
    t_load();
    t_rw_both();
    t_write_frame();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule